// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block sits between the command decoder of a serial NOR flash and its program/erase sequencer. The array is 1 MB, organised as sixteen 64 KB blocks. The block owns three pieces of state: the write-enable latch, an 8-bit status byte holding the protection code, and the power state. Each decoded command arrives as a one-cycle strobe carrying an opcode, a byte address and, for status writes, a new status value. The block then decides whether a page program, sector erase, block erase, chip erase or status write may go ahead. It signals the decision with a one-cycle grant or reject pulse in the cycle after the strobe.

The protected address range comes from a five-bit code in the status byte. That code selects one of four shapes:

- an upper or lower fraction of the array, in 64 KB steps;
- a top or bottom region, in 4 KB steps;
- the whole array;
- nothing.

An active-low pin freezes the protection and lock bits. A deep power-down state makes the block deaf to every command except the wake command.

Power state machine:

- **PWR_AWAKE** is entered at power-on reset. The transition *sleep* (opcode 8) moves it to PWR_SLEEP.
- **PWR_SLEEP** returns to PWR_AWAKE on the transition *wake* (opcode 9).
- Any other command leaves the state where it is.

Top module: `wp_gate_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), `wel`=0, `sr_q`=8'h00, `in_dpd`=0, and `grant` and `reject` are 0.
- R2: Opcode 1 (write enable) sets `wel` in the cycle after the strobe. Opcode 2 (write disable) clears it.
- R3: Opcodes 2, 3, 4, 5, 6 and 7 leave `wel`=0 afterwards, whether the command was granted or rejected.
- R4: Opcodes 3 to 7 (status write, page program, sector erase, block erase, chip erase) issued with `wel`=0 give `reject`=1 for exactly one cycle, in the cycle after the strobe. `grant` and `reject` are never high together.
- R5: The status layout is [4:0]=code C4..C0, [6:5]=lock bits, [7]=free bit. With C4=0, codes 001/010/011/100 in C2..C0 protect 64/128/256/512 KB. With C3=0 that region ends at 0FFFFFh; with C3=1 it starts at 000000h. C2..C0=000 protects nothing.
- R6: With C4=1, codes 001/010/011/10x protect 4/8/16/32 KB. With C3=0 the region is at the top of the array; with C3=1 it is at the bottom.
- R7: The whole array is protected when C4=0 and C2..C0=101, and whenever C2 and C1 are both 1.
- R8: The target of opcode 4 is the aligned 256-byte page containing the address. Opcode 5 targets the aligned 4 KB sector and opcode 6 the aligned 64 KB block. With `wel`=1 the command is rejected if that target overlaps the protected region, otherwise it is granted.
- R9: Chip erase (opcode 7) with `wel`=1 is rejected if any region is protected, otherwise it is granted.
- R10: A status write (opcode 3) with `wel`=1 is granted and loads `sr_wdata` into `sr_q` in the cycle after the strobe.
- R11: If `wp_n` is 0 during a granted status write, `sr_q[6:0]` keep their values and only `sr_q[7]` updates.
- R12: Opcode 8 sets `in_dpd`. While `in_dpd`=1, every opcode other than 9 is ignored: no grant, no reject, and `wel` and `sr_q` are unchanged.
- R13: Opcode 9 while `in_dpd`=1 clears `in_dpd` and leaves `wel` and `sr_q` unchanged. Opcode 9 while awake has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wp_n | input | 1 | Write-protect pin, active low; freezes protection and lock bits |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 4 | Command opcode (1 enable, 2 disable, 3 status write, 4 page, 5 sector, 6 block, 7 chip, 8 sleep, 9 wake) |
| cmd_addr | input | 20 | Target byte address |
| sr_wdata | input | 8 | New status value for opcode 3 |
| wel | output | 1 | Write-enable latch |
| sr_q | output | 8 | Status byte |
| in_dpd | output | 1 | Deep power-down state |
| grant | output | 1 | One-cycle pulse: command allowed |
| reject | output | 1 | One-cycle pulse: command refused |

## Verification
Within a single strobe, a granted status write can both clear the write-enable latch and install a new protection code. The next command must then be judged against the new code with the latch already cleared. Directed sequences write a code and immediately follow it with an erase aimed just inside and just outside the region boundary.

A second overlap exists between the pin lock and the status write. Random status writes are issued with `wp_n` toggled at random, and a bench-side model predicts the partially updated status byte. Commands issued in deep power-down are checked for having changed nothing at all.

// File: rtl/wpg_pkg.sv
`timescale 1ns/1ps
package wpg_pkg;
    localparam int OP_W   = 4;
    localparam int CODE_W = 5;
    localparam int LOCK_W = 2;
    localparam int SR_W   = CODE_W + LOCK_W + 1;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 4'd0,
        OP_WREN  = 4'd1,
        OP_WRDI  = 4'd2,
        OP_WRSR  = 4'd3,
        OP_PROG  = 4'd4,
        OP_SEC   = 4'd5,
        OP_BLK   = 4'd6,
        OP_CHIP  = 4'd7,
        OP_SLEEP = 4'd8,
        OP_WAKE  = 4'd9
    } wpg_op_e;

    typedef enum logic {
        PWR_AWAKE = 1'b0,
        PWR_SLEEP = 1'b1
    } wpg_pwr_e;
endpackage

// File: rtl/wpg_prot_decode.sv
`timescale 1ns/1ps
module wpg_prot_decode #(
    parameter int ADDR_W    = 20,
    parameter int BLK_SHIFT = 16,
    parameter int SEC_SHIFT = 12
) (
    input  logic [4:0]        code,
    output logic              prot_en,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi
);
    localparam int SH_W = $clog2(ADDR_W + 1);

    logic [1:0]        step;
    logic [SH_W-1:0]   shamt;
    logic [ADDR_W-1:0] mask;
    logic              whole;

    always_comb begin
        step    = code[2] ? 2'd3 : (code[1:0] - 2'd1);
        shamt   = (code[4] ? SH_W'(SEC_SHIFT) : SH_W'(BLK_SHIFT)) + SH_W'(step);
        mask    = (ADDR_W'(1) << shamt) - ADDR_W'(1);
        whole   = (code[2] & code[1]) | (!code[4] && code[2:0] == 3'b101);
        prot_en = 1'b1;
        prot_lo = '0;
        prot_hi = '1;
        if (code[2:0] == 3'b000) begin
            prot_en = 1'b0;
        end else if (whole) begin
            prot_lo = '0;
        end else if (code[3]) begin
            prot_hi = mask;
        end else begin
            prot_lo = ~mask;
        end
    end
endmodule

// File: rtl/wpg_span_check.sv
`timescale 1ns/1ps
module wpg_span_check
    import wpg_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 8,
    parameter int SEC_SHIFT  = 12,
    parameter int BLK_SHIFT  = 16
) (
    input  wpg_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              prot_en,
    input  logic [ADDR_W-1:0] prot_lo,
    input  logic [ADDR_W-1:0] prot_hi,
    output logic              hit
);
    logic [ADDR_W-1:0] mask, first, last;

    always_comb begin
        case (op)
            OP_PROG: mask = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);
            OP_SEC:  mask = (ADDR_W'(1) << SEC_SHIFT) - ADDR_W'(1);
            OP_BLK:  mask = (ADDR_W'(1) << BLK_SHIFT) - ADDR_W'(1);
            default: mask = '0;
        endcase
        first = addr & ~mask;
        last  = addr | mask;
        hit   = prot_en && !((last < prot_lo) || (first > prot_hi));
    end
endmodule

// File: rtl/wpg_power_fsm.sv
`timescale 1ns/1ps
module wpg_power_fsm
    import wpg_pkg::*;
(
    input  logic    clk,
    input  logic    por_n,
    input  logic    cmd_valid,
    input  wpg_op_e op,
    output logic    cmd_live,
    output logic    in_dpd
);
    wpg_pwr_e state, state_nx;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= PWR_AWAKE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PWR_AWAKE: if (cmd_valid && op == OP_SLEEP) state_nx = PWR_SLEEP;
            PWR_SLEEP: if (cmd_valid && op == OP_WAKE)  state_nx = PWR_AWAKE;
            default:   state_nx = PWR_AWAKE;
        endcase
    end

    always_comb begin
        cmd_live = cmd_valid && (state == PWR_AWAKE);
        in_dpd   = (state == PWR_SLEEP);
    end

    p_sleep_enter_r12: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_live && op == OP_SLEEP) |=> in_dpd);
    p_wake_exit_r13: assert property (@(posedge clk) disable iff (!por_n)
        (in_dpd && cmd_valid && op == OP_WAKE) |=> !in_dpd);
endmodule

// File: rtl/wp_gate_ctrl.sv
`timescale 1ns/1ps
module wp_gate_ctrl
    import wpg_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 8,
    parameter int SEC_SHIFT  = 12,
    parameter int BLK_SHIFT  = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [SR_W-1:0]   sr_wdata,
    output logic              wel,
    output logic [SR_W-1:0]   sr_q,
    output logic              in_dpd,
    output logic              grant,
    output logic              reject
);
    localparam int LOCKED_W = CODE_W + LOCK_W;

    wpg_op_e           op;
    logic              cmd_live;
    logic              prot_en, hit;
    logic [ADDR_W-1:0] prot_lo, prot_hi;
    logic [SR_W-1:0]   sr_next;

    assign op = wpg_op_e'(cmd_op);

    wpg_power_fsm u_pwr (
        .clk(clk), .por_n(por_n), .cmd_valid(cmd_valid), .op(op),
        .cmd_live(cmd_live), .in_dpd(in_dpd)
    );

    wpg_prot_decode #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .SEC_SHIFT(SEC_SHIFT)) u_dec (
        .code(sr_q[CODE_W-1:0]), .prot_en(prot_en), .prot_lo(prot_lo), .prot_hi(prot_hi)
    );

    wpg_span_check #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
                     .SEC_SHIFT(SEC_SHIFT), .BLK_SHIFT(BLK_SHIFT)) u_span (
        .op(op), .addr(cmd_addr), .prot_en(prot_en), .prot_lo(prot_lo),
        .prot_hi(prot_hi), .hit(hit)
    );

    assign sr_next = wp_n ? sr_wdata
                          : {sr_wdata[SR_W-1:LOCKED_W], sr_q[LOCKED_W-1:0]};

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wel    <= 1'b0;
            sr_q   <= '0;
            grant  <= 1'b0;
            reject <= 1'b0;
        end else begin
            grant  <= 1'b0;
            reject <= 1'b0;
            if (cmd_live) begin
                case (op)
                    OP_WREN: wel <= 1'b1;
                    OP_WRDI: wel <= 1'b0;
                    OP_WRSR: begin
                        wel <= 1'b0;
                        if (wel) begin
                            sr_q  <= sr_next;
                            grant <= 1'b1;
                        end else begin
                            reject <= 1'b1;
                        end
                    end
                    OP_PROG, OP_SEC, OP_BLK: begin
                        wel    <= 1'b0;
                        grant  <= wel && !hit;
                        reject <= !wel || hit;
                    end
                    OP_CHIP: begin
                        wel    <= 1'b0;
                        grant  <= wel && !prot_en;
                        reject <= !wel || prot_en;
                    end
                    default: ;
                endcase
            end
        end
    end

    p_one_verdict_r4: assert property (@(posedge clk) disable iff (!por_n)
        !(grant && reject));
    p_grant_needs_wel_r4: assert property (@(posedge clk) disable iff (!por_n)
        grant |-> $past(wel));
    p_wel_drop_r3: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_live && (op == OP_WRDI || op == OP_WRSR || op == OP_PROG ||
                      op == OP_SEC || op == OP_BLK || op == OP_CHIP)) |=> !wel);
    p_chip_block_r9: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_live && op == OP_CHIP && prot_en) |=> reject);
    p_lock_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
        !wp_n |=> $stable(sr_q[LOCKED_W-1:0]));
    p_sleep_ignore_r12: assert property (@(posedge clk) disable iff (!por_n)
        (in_dpd && cmd_valid && op != OP_WAKE) |=>
            ($stable(wel) && $stable(sr_q) && !grant && !reject));
    p_wake_keep_r13: assert property (@(posedge clk) disable iff (!por_n)
        (in_dpd && cmd_valid && op == OP_WAKE) |=> ($stable(wel) && $stable(sr_q)));
endmodule

// File: tb/wp_gate_ctrl_tb.sv
`timescale 1ns/1ps
module wp_gate_ctrl_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wp_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [19:0] cmd_addr = 20'd0;
    logic [7:0]  sr_wdata = 8'd0;
    logic        wel, in_dpd, grant, reject;
    logic [7:0]  sr_q;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    bit   m_wel = 1'b0;
    bit   m_dpd = 1'b0;
    logic [7:0] m_sr = 8'd0;

    always #5 clk = ~clk;

    wp_gate_ctrl u_dut (
        .clk(clk), .por_n(por_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .sr_wdata(sr_wdata),
        .wel(wel), .sr_q(sr_q), .in_dpd(in_dpd), .grant(grant), .reject(reject)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void prot_of(input logic [4:0] c, output bit en,
                                    output int lo, output int hi);
        en = 1; lo = 0; hi = 32'hFFFFF;
        casez (c)
            5'b??000: en = 0;
            5'b??11?: ;
            5'b0?101: ;
            5'b00001: lo = 32'hF0000;
            5'b00010: lo = 32'hE0000;
            5'b00011: lo = 32'hC0000;
            5'b00100: lo = 32'h80000;
            5'b01001: hi = 32'h0FFFF;
            5'b01010: hi = 32'h1FFFF;
            5'b01011: hi = 32'h3FFFF;
            5'b01100: hi = 32'h7FFFF;
            5'b10001: lo = 32'hFF000;
            5'b10010: lo = 32'hFE000;
            5'b10011: lo = 32'hFC000;
            5'b1010?: lo = 32'hF8000;
            5'b11001: hi = 32'h00FFF;
            5'b11010: hi = 32'h01FFF;
            5'b11011: hi = 32'h03FFF;
            5'b1110?: hi = 32'h07FFF;
            default:  en = 0;
        endcase
    endfunction

    function automatic string tag_of(input int op, input bit dpd);
        if (dpd) return (op == 9) ? "R13" : "R12";
        case (op)
            1: return "R2";
            2: return "R3";
            3: return "R10";
            4, 5, 6: return "R8";
            7: return "R9";
            8: return "R12";
            9: return "R13";
            default: return "R4";
        endcase
    endfunction

    task automatic issue(input int op, input logic [19:0] a, input logic [7:0] d,
                         input bit wp, input string tag);
        bit eg = 0, er = 0, nwel = m_wel, ndpd = m_dpd, en;
        logic [7:0] nsr = m_sr;
        int lo, hi, sz, first;
        prot_of(m_sr[4:0], en, lo, hi);
        if (m_dpd) begin
            if (op == 9) ndpd = 0;
        end else begin
            case (op)
                1: nwel = 1;
                2: nwel = 0;
                3: begin
                    nwel = 0;
                    if (m_wel) begin eg = 1; nsr = wp ? d : {d[7], m_sr[6:0]}; end
                    else er = 1;
                end
                4, 5, 6: begin
                    sz = (op == 4) ? 256 : (op == 5) ? 4096 : 65536;
                    first = int'(a) - (int'(a) % sz);
                    nwel = 0;
                    if (m_wel && !(en && first + sz - 1 >= lo && first <= hi)) eg = 1;
                    else er = 1;
                end
                7: begin nwel = 0; if (m_wel && !en) eg = 1; else er = 1; end
                8: ndpd = 1;
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'(op); cmd_addr = a; sr_wdata = d; wp_n = wp;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({tag, " wel"}, 32'(wel), 32'(nwel));
        chk({tag, " sr"}, 32'(sr_q), 32'(nsr));
        chk({tag, " dpd"}, 32'(in_dpd), 32'(ndpd));
        chk({tag, " grant"}, 32'(grant), 32'(eg));
        chk({tag, " reject"}, 32'(reject), 32'(er));
        m_wel = nwel; m_sr = nsr; m_dpd = ndpd;
    endtask

    task automatic set_code(input logic [7:0] v);
        issue(1, 20'h0, 8'h0, 1, "R2");
        issue(3, 20'h0, v, 1, "R10");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 wel", 32'(wel), 0);
        chk("R1 sr", 32'(sr_q), 0);
        chk("R1 dpd", 32'(in_dpd), 0);
        chk("R1 grant", 32'(grant), 0);
        chk("R1 reject", 32'(reject), 0);
        por_n = 1'b1;

        issue(4, 20'h00100, 8'h0, 1, "R4");          // R4 program without latch
        issue(1, 20'h0, 8'h0, 1, "R2");
        issue(2, 20'h0, 8'h0, 1, "R2");
        issue(3, 20'h0, 8'h1F, 1, "R4");             // R4 status write without latch
        issue(1, 20'h0, 8'h0, 1, "R2");
        issue(7, 20'h0, 8'h0, 1, "R9");              // R9 chip erase, nothing protected

        set_code(8'h03);                             // R5 upper 256 KB
        issue(1, 0, 0, 1, "R2"); issue(6, 20'hB0000, 0, 1, "R5");
        issue(1, 0, 0, 1, "R2"); issue(6, 20'hC0000, 0, 1, "R5");
        issue(1, 0, 0, 1, "R2"); issue(7, 20'h0, 0, 1, "R9");
        set_code(8'h0A);                             // R5 lower 128 KB
        issue(1, 0, 0, 1, "R2"); issue(5, 20'h1F123, 0, 1, "R5");
        issue(1, 0, 0, 1, "R2"); issue(5, 20'h20000, 0, 1, "R5");
        set_code(8'h12);                             // R6 top 8 KB
        issue(1, 0, 0, 1, "R2"); issue(5, 20'hFE000, 0, 1, "R6");
        issue(1, 0, 0, 1, "R2"); issue(5, 20'hFD000, 0, 1, "R6");
        issue(1, 0, 0, 1, "R2"); issue(4, 20'hFDFFF, 0, 1, "R8");
        set_code(8'h1D);                             // R6 bottom 32 KB
        issue(1, 0, 0, 1, "R2"); issue(5, 20'h07000, 0, 1, "R6");
        issue(1, 0, 0, 1, "R2"); issue(5, 20'h08000, 0, 1, "R6");
        set_code(8'h0D);                             // R7 whole array
        issue(1, 0, 0, 1, "R2"); issue(4, 20'h40000, 0, 1, "R7");
        set_code(8'h16);                             // R7 whole array
        issue(1, 0, 0, 1, "R2"); issue(4, 20'h40000, 0, 1, "R7");

        set_code(8'h00);
        issue(1, 0, 0, 1, "R2"); issue(3, 0, 8'hFF, 0, "R11");   // R11 only bit 7
        issue(1, 0, 0, 1, "R2");
        issue(8, 0, 0, 1, "R12");
        issue(2, 0, 0, 1, "R12"); issue(3, 0, 8'h55, 1, "R12");
        issue(7, 0, 0, 1, "R12");
        issue(9, 0, 0, 1, "R13");                    // R13 latch kept
        issue(9, 0, 0, 1, "R13");                    // R13 wake while awake

        for (int i = 0; i < 2500; i++) begin
            int op;
            bit wp;
            op = int'($urandom % 13);
            if (op > 9) op = 1;
            wp = ($urandom % 4) != 0;
            issue(op, 20'($urandom), 8'($urandom), wp, tag_of(op, m_dpd));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule